// File: doc/BRIEF.md
# Step-Command Trigger Sequencer

This block runs a short stored program of step commands and produces timed, single-cycle trigger pulses in response to external trigger inputs. Each step names one action. It can stall until a chosen input rises, fire a pulse on a chosen output, stall on one of two delay timers, loop back a counted number of times, or jump unconditionally. Chains of events with fixed delays can therefore be built without a processor in the loop. One example is a zero-crossing input followed by a delayed gate pulse and then a burst of evenly spaced converter triggers.

The program, the two timer limits and the loop limit are static configuration inputs. Loading them is left to the surrounding logic. Execution begins at step 0 when enable and start are both high. It continues until enable is cleared. At an 8 MHz sequencer clock, a timer limit of 16000 gives a 2 ms wait and a limit of 8000 gives a 1 ms wait.

Top module: `trig_seq`

## Requirements
- R1: After reset the sequencer is idle. `busy_o` is 0, every bit of `trig_out_o` is 0 and `step_o` is 0.
- R2: An idle sequencer starts only at a clock edge where `en_i` and `start_i` are both 1. On that edge it starts at step 0. With `en_i` high and `start_i` low it stays idle.
- R3: Step i is held in `queue_i[8*i +: 8]`, so four steps share each 32-bit queue word. Bits [7:5] of a step are the opcode and bits [4:0] are the operand. The opcodes are: 1 wait-high, 2 trigger, 3 wait on timer 0, 4 wait on timer 1, 5 counted jump and 6 jump.
- R4: A wait-high step advances only on a rising edge of the input selected by its operand, seen between two consecutive clock edges. An input that is already high when the step is reached does not advance it. An input that rises while the step is active advances it, and the next step executes on the following edge.
- R5: A trigger step drives the output selected by its operand high for exactly one cycle, starting right after the edge at which the step executes. It then moves to the next step. At most one output is high at a time.
- R6: A timer wait step starts its timer from zero each time the step is entered. It advances when the count equals its limit, so it occupies limit+1 cycles. Timer 0 and timer 1 use their own limits.
- R7: A counted jump branches to the step in its operand while the loop counter is below its limit. It increments the counter on each branch. At the limit it falls through to the next step and clears the counter. The loop body therefore runs limit+1 times on every pass.
- R8: A jump step moves the step pointer to its operand on the next edge.
- R9: A clock edge with `en_i` low returns the sequencer to idle. All outputs go low, the step pointer goes to 0, and no pending wait completes later.
- R10: Opcodes 0 and 7 do nothing and advance one step per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low forces idle |
| start_i | input | 1 | Start request, taken together with enable |
| queue_i | input | 128 | Step queue, four 8-bit steps per word |
| t0_lim_i | input | 16 | Timer 0 limit |
| t1_lim_i | input | 16 | Timer 1 limit |
| loop_lim_i | input | 8 | Loop counter limit |
| trig_in_i | input | 16 | External trigger inputs |
| trig_out_o | output | 32 | Trigger output pulses |
| busy_o | output | 1 | Sequencer is running |
| step_o | output | 4 | Current step pointer |

## Verification
The hardest state to reach from the ports is the second pass through a counted loop. Reaching it shows that the counter cleared on fall-through and that the timers restart from zero on every entry. The bench runs a ten-step program to completion and lets it jump back to its wait-high step. There it checks that a trigger input still held high does not restart the program. It then lowers and re-raises the input and counts the pulses of the second pass. Pulse-to-pulse distances are measured in cycles from a free-running counter, so each timer and branch cost is checked as an exact interval.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
  localparam int CMD_W = 8;
  localparam int OP_W  = 3;
  localparam int ARG_W = CMD_W - OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_NOP0     = 3'd0,
    OP_WAIT_HI  = 3'd1,
    OP_TRIG     = 3'd2,
    OP_WAIT_T0  = 3'd3,
    OP_WAIT_T1  = 3'd4,
    OP_JMP_LOOP = 3'd5,
    OP_JMP      = 3'd6,
    OP_NOP7     = 3'd7
  } op_e;

  typedef struct packed {
    op_e              op;
    logic [ARG_W-1:0] arg;
  } cmd_t;

  typedef enum logic {ST_IDLE, ST_RUN} state_e;
endpackage

// File: rtl/trig_seq_edge.sv
module trig_seq_edge #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= in_i;
  end

  assign rise_o = in_i & ~prev_q;
endmodule

// File: rtl/trig_seq_timer.sv
module trig_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] lim_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == lim_i);
endmodule

// File: rtl/trig_seq_loop.sv
module trig_seq_loop #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         hit_i,
  input  logic [W-1:0] lim_i,
  output logic         at_lim_o
);
  logic [W-1:0] cnt_q;

  assign at_lim_o = (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (hit_i)   cnt_q <= at_lim_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int N_STEPS        = 16,
  parameter int STEPS_PER_WORD = 4,
  parameter int N_IN           = 16,
  parameter int N_OUT          = 32,
  parameter int TMR_W          = 16,
  parameter int LOOP_W         = 8,
  localparam int PTR_W         = $clog2(N_STEPS),
  localparam int IN_W          = $clog2(N_IN),
  localparam int Q_WORDS       = N_STEPS / STEPS_PER_WORD,
  localparam int WORD_W        = CMD_W * STEPS_PER_WORD,
  localparam int Q_BITS        = Q_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [Q_BITS-1:0] queue_i,
  input  logic [TMR_W-1:0]  t0_lim_i,
  input  logic [TMR_W-1:0]  t1_lim_i,
  input  logic [LOOP_W-1:0] loop_lim_i,
  input  logic [N_IN-1:0]   trig_in_i,
  output logic [N_OUT-1:0]  trig_out_o,
  output logic              busy_o,
  output logic [PTR_W-1:0]  step_o
);
  localparam logic [N_OUT-1:0] OUT_ONE = N_OUT'(1);

  // unpack queue words into steps
  cmd_t steps [N_STEPS];
  for (genvar w = 0; w < Q_WORDS; w++) begin : g_word
    for (genvar s = 0; s < STEPS_PER_WORD; s++) begin : g_slot
      assign steps[w*STEPS_PER_WORD + s] = cmd_t'(queue_i[w*WORD_W + s*CMD_W +: CMD_W]);
    end
  end

  state_e           state_q;
  logic [PTR_W-1:0] ptr_q, ptr_nxt;
  logic [N_OUT-1:0] out_q, pulse;
  cmd_t             cur;
  logic             exec, adv, jmp, ptr_ld, loop_hit, loop_at_lim;
  logic [N_IN-1:0]  rise;
  logic [1:0]       tmr_run, tmr_done;
  logic [TMR_W-1:0] tmr_lim [2];

  assign cur        = steps[ptr_q];
  assign exec       = (state_q == ST_RUN) && en_i;
  assign tmr_lim[0] = t0_lim_i;
  assign tmr_lim[1] = t1_lim_i;

  trig_seq_edge #(.W(N_IN)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   (trig_in_i),
    .rise_o (rise)
  );

  for (genvar g = 0; g < 2; g++) begin : g_tmr
    assign tmr_run[g] = exec && (cur.op == ((g == 0) ? OP_WAIT_T0 : OP_WAIT_T1));
    trig_seq_timer #(.W(TMR_W)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (ptr_ld || !exec),
      .run_i  (tmr_run[g]),
      .lim_i  (tmr_lim[g]),
      .done_o (tmr_done[g])
    );
  end

  trig_seq_loop #(.W(LOOP_W)) u_loop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (state_q == ST_IDLE),
    .hit_i    (loop_hit),
    .lim_i    (loop_lim_i),
    .at_lim_o (loop_at_lim)
  );

  always_comb begin
    adv      = 1'b0;
    jmp      = 1'b0;
    loop_hit = 1'b0;
    pulse    = '0;
    if (exec) begin
      unique case (cur.op)
        OP_WAIT_HI:  adv = rise[cur.arg[IN_W-1:0]];
        OP_TRIG: begin
          adv   = 1'b1;
          pulse = OUT_ONE << cur.arg;
        end
        OP_WAIT_T0:  adv = tmr_done[0];
        OP_WAIT_T1:  adv = tmr_done[1];
        OP_JMP_LOOP: begin
          loop_hit = 1'b1;
          if (loop_at_lim) adv = 1'b1;
          else             jmp = 1'b1;
        end
        OP_JMP:      jmp = 1'b1;
        default:     adv = 1'b1;
      endcase
    end
  end

  assign ptr_ld  = adv || jmp;
  assign ptr_nxt = jmp ? cur.arg[PTR_W-1:0] : ptr_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      out_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          out_q <= '0;
          ptr_q <= '0;
          if (en_i && start_i) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (!en_i) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            out_q   <= '0;
          end else begin
            out_q <= pulse;
            if (ptr_ld) ptr_q <= ptr_nxt;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign trig_out_o = out_q;
  assign busy_o     = (state_q == ST_RUN);
  assign step_o     = ptr_q;
endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk
  import trig_seq_pkg::*;
#(
  parameter int N_STEPS = 16,
  parameter int N_IN    = 16,
  parameter int N_OUT   = 32,
  parameter int TMR_W   = 16,
  parameter int LOOP_W  = 8,
  parameter int PTR_W   = 4,
  parameter int Q_BITS  = 128
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              start_i,
  input logic [Q_BITS-1:0] queue_i,
  input logic [N_OUT-1:0]  trig_out_o,
  input logic              busy_o,
  input logic [PTR_W-1:0]  step_o
);
  cmd_t cur;
  assign cur = cmd_t'(queue_i[step_o*CMD_W +: CMD_W]);

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !(en_i && start_i)) |=> !busy_o);

  // R2
  start_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && en_i && start_i) |=> (busy_o && step_o == '0));

  // R9
  stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && trig_out_o == '0 && step_o == '0));

  // R5
  out_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trig_out_o));

  // R5
  trig_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && en_i && cur.op == OP_TRIG) |=>
      (trig_out_o[$past(cur.arg)] && step_o == PTR_W'($past(step_o) + 1'b1)));

  // R5
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && en_i && cur.op != OP_TRIG) |=> (trig_out_o == '0));

  // R8
  jmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && en_i && cur.op == OP_JMP) |=> (step_o == $past(cur.arg[PTR_W-1:0])));
endmodule

bind trig_seq trig_seq_chk #(
  .N_STEPS (N_STEPS),
  .N_IN    (N_IN),
  .N_OUT   (N_OUT),
  .TMR_W   (TMR_W),
  .LOOP_W  (LOOP_W),
  .PTR_W   (PTR_W),
  .Q_BITS  (Q_BITS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .start_i    (start_i),
  .queue_i    (queue_i),
  .trig_out_o (trig_out_o),
  .busy_o     (busy_o),
  .step_o     (step_o)
);

// File: tb/trig_seq_tb.sv
module trig_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int T0 = 6;
  localparam int T1 = 3;
  localparam int LP = 2;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic         start_i = 1'b0;
  logic [127:0] queue_i = '0;
  logic [15:0]  t0_lim_i = 16'(T0);
  logic [15:0]  t1_lim_i = 16'(T1);
  logic [7:0]   loop_lim_i = 8'(LP);
  logic [15:0]  trig_in_i = '0;
  logic [31:0]  trig_out_o;
  logic         busy_o;
  logic [3:0]   step_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int cnt_out [32];

  trig_seq u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .start_i(start_i),
    .queue_i(queue_i), .t0_lim_i(t0_lim_i), .t1_lim_i(t1_lim_i),
    .loop_lim_i(loop_lim_i), .trig_in_i(trig_in_i),
    .trig_out_o(trig_out_o), .busy_o(busy_o), .step_o(step_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  initial for (int k = 0; k < 32; k++) cnt_out[k] = 0;
  always @(negedge clk_i)
    for (int k = 0; k < 32; k++) if (trig_out_o[k]) cnt_out[k] = cnt_out[k] + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] cmd(input int op, input int arg);
    return {3'(op), 5'(arg)};
  endfunction

  task automatic wait_pulse(input int idx, input int lim, output int at);
    at = -1;
    for (int n = 0; n < lim; n++) begin
      @(negedge clk_i);
      if (trig_out_o[idx]) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic kick();
    en_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy_o), 0);
    chk("R1 outputs", int'(trig_out_o), 0);
    chk("R1 step", int'(step_o), 0);
  endtask

  task automatic t_no_start();
    en_i = 1'b1; start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    chk("R2 enable alone", int'(busy_o), 0);
    en_i = 1'b0;
    @(negedge clk_i);
  endtask

  // R3 layout: step i at queue_i[8*i +: 8], opcode [7:5], operand [4:0]
  task automatic load_ref();
    queue_i = '0;
    queue_i[0*8 +: 8] = cmd(1, 15);
    queue_i[1*8 +: 8] = cmd(2, 12);
    queue_i[2*8 +: 8] = cmd(3, 0);
    queue_i[3*8 +: 8] = cmd(2, 24);
    queue_i[4*8 +: 8] = cmd(4, 0);
    queue_i[5*8 +: 8] = cmd(2, 26);
    queue_i[6*8 +: 8] = cmd(3, 0);
    queue_i[7*8 +: 8] = cmd(2, 26);
    queue_i[8*8 +: 8] = cmd(5, 6);
    queue_i[9*8 +: 8] = cmd(6, 0);
  endtask

  task automatic t_ref_program();
    int c, a, b, p1, p2, p3, p4, n12, n24, n26;
    load_ref();
    kick();
    chk("R2 started", int'(busy_o), 1);
    chk("R2 start step", int'(step_o), 0);
    n12 = cnt_out[12];
    repeat (5) @(negedge clk_i);
    chk("R4 stall without edge", cnt_out[12] - n12, 0);
    trig_in_i[15] = 1'b1;
    c = cyc;
    wait_pulse(12, 20, a);
    chk("R4 edge to first pulse", a - c, 2);
    @(negedge clk_i);
    chk("R5 single cycle", int'(trig_out_o[12]), 0);
    wait_pulse(24, 40, b);
    chk("R6 timer0 gap", b - a, T0 + 2);
    wait_pulse(26, 40, p1);
    chk("R6 timer1 gap", p1 - b, T1 + 2);
    wait_pulse(26, 40, p2);
    chk("R6 fresh timer0", p2 - p1, T0 + 2);
    wait_pulse(26, 40, p3);
    chk("R7 loop branch gap", p3 - p2, T0 + 3);
    wait_pulse(26, 40, p4);
    chk("R7 last loop gap", p4 - p3, T0 + 3);
    @(negedge clk_i);
    chk("R7 fall through", int'(step_o), 9);
    @(negedge clk_i);
    chk("R8 jump to zero", int'(step_o), 0);
    n26 = cnt_out[26];
    n12 = cnt_out[12];
    repeat (30) @(negedge clk_i);
    chk("R7 no extra loop", cnt_out[26] - n26, 0);
    chk("R4 held level ignored", cnt_out[12] - n12, 0);
    // second pass
    trig_in_i[15] = 1'b0;
    repeat (2) @(negedge clk_i);
    n12 = cnt_out[12]; n24 = cnt_out[24]; n26 = cnt_out[26];
    trig_in_i[15] = 1'b1;
    repeat (60) @(negedge clk_i);
    chk("R7 second pass loops", cnt_out[26] - n26, LP + 2);
    chk("R4 second pass start", cnt_out[12] - n12, 1);
    chk("R6 second pass gate", cnt_out[24] - n24, 1);
  endtask

  task automatic t_disable();
    int a, n24;
    trig_in_i[15] = 1'b0;
    repeat (2) @(negedge clk_i);
    trig_in_i[15] = 1'b1;
    wait_pulse(12, 20, a);
    chk("R4 rerun start", int'(a > 0), 1);
    repeat (3) @(negedge clk_i);
    n24 = cnt_out[24];
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R9 idle", int'(busy_o), 0);
    chk("R9 outputs low", int'(trig_out_o), 0);
    chk("R9 step cleared", int'(step_o), 0);
    repeat (20) @(negedge clk_i);
    chk("R9 wait abandoned", cnt_out[24] - n24, 0);
    en_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R2 no start request", int'(busy_o), 0);
    kick();
    chk("R9 restart at zero", int'(step_o), 0);
    repeat (10) @(negedge clk_i);
    chk("R4 held input no edge", int'(step_o), 0);
    en_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic t_nop();
    int a, b;
    queue_i = '0;
    queue_i[0*8 +: 8] = cmd(2, 1);
    queue_i[1*8 +: 8] = cmd(0, 9);
    queue_i[2*8 +: 8] = cmd(7, 3);
    queue_i[3*8 +: 8] = cmd(2, 2);
    queue_i[4*8 +: 8] = cmd(6, 4);
    kick();
    wait_pulse(1, 10, a);
    wait_pulse(2, 10, b);
    chk("R10 no-op steps", b - a, 3);
    repeat (4) @(negedge clk_i);
    chk("R8 self jump parks", int'(step_o), 4);
    chk("R5 parked quiet", int'(trig_out_o), 0);
    en_i = 1'b0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_no_start();
    t_ref_program();
    t_disable();
    t_nop();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule